// File: doc/BRIEF.md
# Register-Driven SPI Command Engine

This block is a serial-flash SPI master driven through a small byte-wide register bus. Software places a command opcode and a packed pair of byte counts in registers, loads the outgoing payload into an eight-entry ring buffer through a single auto-incrementing data port, and then sets a go bit. The engine drops chip select, shifts out the opcode, then the payload bytes taken from the ring, then clocks in the requested response bytes, and finally raises chip select again.

Every byte clocked after the opcode writes its received MISO value back into the ring at the current pointer, and the engine advances that pointer. So after a command the pointer sits at the sum of both counts, and the response bytes live at ring indices starting at the write count. Software rewinds the pointer and reads the ring back through the same data port. The pointer is visible in a status byte, and the SPI clock rate is chosen from three divisions of the block clock.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCLK is low, and offsets 0x0, 0x1 and 0x2 read 0x00. Offset 0xD reads 0x30, which means rate code 11 and pointer 0.
- R2: Offset 0x1 holds the read count in bits 7:4 and the write count in bits 3:0. A nibble written above 8 is stored as 8. The register reads back unchanged after a command completes.
- R3: Each write or read of the data port at offset 0xC accesses the ring entry at the pointer, then advances the pointer by one, modulo 8. Bits 2:0 of offset 0xD show the pointer. Writing a 1 to bit 4 of offset 0x2 sets the pointer to 0.
- R4: Writing a 1 to bit 0 of offset 0x2 starts a command. That bit reads 1 while the command runs and returns to 0 by itself afterwards.
- R5: The frame is SPI mode 0, MSB first. MOSI changes only while SCLK is low. The bytes sent are the opcode, then write-count bytes read from the ring starting at the pointer, then read-count bytes of 0xFF.
- R6: The MISO byte of every post-opcode byte is stored at the pointer, which then advances. After a command the pointer has moved by the write count plus the read count, modulo 8. The response bytes occupy the ring entries from the write count onward.
- R7: A command produces exactly 8 × (1 + write count + read count) rising SCLK edges. This holds when the write count is 0, and the last response byte is still stored.
- R8: Bits 5:4 of offset 0xD set the SCLK period in block-clock cycles: 01 gives 2, 10 gives 3, and 11 or 00 give 4.
- R9: After the last bit, chip select stays high for at least one SCLK period before the go bit reads 0.
- R10: While a command runs, writes to offsets 0x0, 0x1, 0xC and 0xD are ignored, and so is the pointer-reset bit. Data-port reads do not advance the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, the rate reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The embedded properties check the following on every cycle:
- SCLK stays low whenever chip select is high.
- MOSI holds still while SCLK is high.
- Chip select, once raised, stays high for more than one cycle.
- The bit-phase counter stays inside the selected period.
- The ring pointer only steps by one or clears.
- Opcode, counts and rate stay frozen while busy.

Only the bench scenarios can show the following:
- The exact byte stream on MOSI.
- The SCLK period for each rate code.
- The edge count for zero-write commands.
- That received bytes land at the right ring indices, including 16-byte wrap-around.
- That writes made while busy leave no trace.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
   localparam logic [3:0] OFS_OPCODE = 4'h0;
   localparam logic [3:0] OFS_COUNT  = 4'h1;
   localparam logic [3:0] OFS_CTRL   = 4'h2;
   localparam logic [3:0] OFS_DATA   = 4'hC;
   localparam logic [3:0] OFS_CFG    = 4'hD;
   localparam int CTRL_GO_BIT  = 0;
   localparam int CTRL_CLR_BIT = 4;

   typedef enum logic [1:0] {SEQ_IDLE, SEQ_SHIFT, SEQ_GAP} seq_state_t;

   function automatic logic [3:0] clamp_cnt(input logic [3:0] n, input logic [3:0] mx);
      return (n > mx) ? mx : n;
   endfunction
endpackage

// File: rtl/spi_rate_sel.sv
module spi_rate_sel #(
   parameter int DIV_FAST = 2,
   parameter int DIV_MID  = 3,
   parameter int DIV_SLOW = 4,
   parameter int DIV_W    = 3
) (
   input  logic [1:0]       rate,
   output logic [DIV_W-1:0] div,
   output logic [DIV_W-1:0] low_len
);
   generate
      if (DIV_FAST < 2 || DIV_MID < 2 || DIV_SLOW < 2)
         $error("spi_rate_sel: every divisor must be at least 2");
      if ((1 << DIV_W) <= DIV_SLOW)
         $error("spi_rate_sel: DIV_W too narrow");
   endgenerate

   always_comb begin
      case (rate)
         2'b01:   div = DIV_W'(DIV_FAST);
         2'b10:   div = DIV_W'(DIV_MID);
         default: div = DIV_W'(DIV_SLOW);
      endcase
      // SCLK low for the longer half, high for the shorter one
      low_len = div - (div >> 1);
   end
endmodule

// File: rtl/spi_ring_buf.sv
module spi_ring_buf #(
   parameter int DEPTH = 8,
   parameter int DW    = 8,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             we,
   input  logic             adv,
   input  logic [DW-1:0]    wdata,
   output logic [PTR_W-1:0] ptr,
   output logic [DW-1:0]    cur,
   output logic [DW-1:0]    nxt
);
   generate
      if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2)
         $error("spi_ring_buf: DEPTH must be a power of two");
   endgenerate

   logic [DW-1:0] mem [DEPTH];

   assign cur = mem[ptr];
   assign nxt = mem[ptr + PTR_W'(1)];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (we) mem[ptr] <= wdata;
         if (clr)      ptr <= '0;
         else if (adv) ptr <= ptr + PTR_W'(1);
      end
   end

   // R3: pointer moves by at most one step per cycle unless cleared
   p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (ptr == $past(ptr) || ptr == $past(ptr) + PTR_W'(1)));
   p_ptr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> ptr == '0);
endmodule

// File: rtl/spi_seq.sv
module spi_seq
   import spi_cmd_pkg::*;
#(
   parameter int CNT_W = 4,
   parameter int DIV_W = 3,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [7:0]       opcode,
   input  logic [CNT_W-1:0] wr_cnt,
   input  logic [CNT_W-1:0] rd_cnt,
   input  logic [DIV_W-1:0] div,
   input  logic [DIV_W-1:0] low_len,
   input  logic [7:0]       ring_cur,
   input  logic [7:0]       ring_nxt,
   input  logic             miso,
   output logic             busy,
   output logic             sclk,
   output logic             mosi,
   output logic             cs_n,
   output logic             ring_we,
   output logic [7:0]       ring_wdata
);
   seq_state_t       st;
   logic [DIV_W-1:0] ph;
   logic [2:0]       bit_i;
   logic [IDX_W-1:0] byte_i;
   logic [7:0]       tx, rx;

   logic samp, bit_end, byte_end, last_byte, store;
   logic [IDX_W-1:0] nb;
   logic [7:0] rx_next, tx_src;

   assign samp      = (st == SEQ_SHIFT) && (ph == low_len);
   assign rx_next   = {rx[6:0], miso};
   assign bit_end   = (st == SEQ_SHIFT) && (ph == div - DIV_W'(1));
   assign byte_end  = bit_end && (bit_i == 3'd0);
   assign last_byte = byte_i == (IDX_W'(wr_cnt) + IDX_W'(rd_cnt));
   assign store     = byte_end && (byte_i != '0);
   assign nb        = byte_i + IDX_W'(1);
   assign tx_src    = (nb <= IDX_W'(wr_cnt)) ? (store ? ring_nxt : ring_cur) : 8'hFF;

   assign ring_we    = store;
   assign ring_wdata = samp ? rx_next : rx;
   assign busy       = st != SEQ_IDLE;
   assign cs_n       = st != SEQ_SHIFT;
   assign sclk       = (st == SEQ_SHIFT) && (ph >= low_len);
   assign mosi       = (st == SEQ_SHIFT) ? tx[7] : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= SEQ_IDLE; ph <= '0; bit_i <= 3'd7; byte_i <= '0;
         tx <= '0; rx <= '0;
      end else begin
         case (st)
            SEQ_IDLE: if (start) begin
               st <= SEQ_SHIFT; ph <= '0; bit_i <= 3'd7; byte_i <= '0; tx <= opcode;
            end
            SEQ_SHIFT: begin
               if (samp) rx <= rx_next;
               if (bit_end) begin
                  ph <= '0;
                  if (bit_i == 3'd0) begin
                     bit_i <= 3'd7;
                     if (last_byte) st <= SEQ_GAP;
                     else begin
                        byte_i <= nb;
                        tx     <= tx_src;
                     end
                  end else begin
                     bit_i <= bit_i - 3'd1;
                     tx    <= {tx[6:0], 1'b0};
                  end
               end else begin
                  ph <= ph + DIV_W'(1);
               end
            end
            SEQ_GAP: begin
               if (ph == div - DIV_W'(1)) begin
                  st <= SEQ_IDLE; ph <= '0;
               end else begin
                  ph <= ph + DIV_W'(1);
               end
            end
            default: st <= SEQ_IDLE;
         endcase
      end
   end

   // R5: clock is parked low whenever the device is deselected
   p_sclk_parked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);
   // R5: data only moves while SCLK is low (mode 0)
   p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));
   // R9: deselect lasts more than a single cycle
   p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |=> cs_n);
   // R8: phase counter stays within the selected period
   p_phase_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ph < div);
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
   import spi_cmd_pkg::*;
#(
   parameter int DEPTH    = 8,
   parameter int MAX_CNT  = 8,
   parameter int DIV_FAST = 2,
   parameter int DIV_MID  = 3,
   parameter int DIV_SLOW = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] reg_addr,
   input  logic       reg_wr,
   input  logic       reg_rd,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       spi_sclk,
   output logic       spi_mosi,
   input  logic       spi_miso,
   output logic       spi_cs_n
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = 4;
   localparam int DIV_W = $clog2(DIV_SLOW + 1);
   localparam int IDX_W = $clog2(2 * MAX_CNT + 2);

   generate
      if (DEPTH > 8) $error("spi_cmd_engine: pointer field holds at most 3 bits");
      if (MAX_CNT > 15 || MAX_CNT < 1) $error("spi_cmd_engine: MAX_CNT must fit a nibble");
   endgenerate

   logic [7:0] opcode_q, cnt_q;
   logic [1:0] rate_q;
   logic       busy, acc_wr, host_data_wr, host_data_rd, go, clr;
   logic       eng_we;
   logic [7:0] eng_wdata, ring_cur, ring_nxt;
   logic [PTR_W-1:0] ptr;
   logic [DIV_W-1:0] div, low_len;

   assign acc_wr       = reg_wr && !busy;
   assign host_data_wr = acc_wr && (reg_addr == OFS_DATA);
   assign host_data_rd = reg_rd && !busy && (reg_addr == OFS_DATA);
   assign go           = acc_wr && (reg_addr == OFS_CTRL) && reg_wdata[CTRL_GO_BIT];
   assign clr          = acc_wr && (reg_addr == OFS_CTRL) && reg_wdata[CTRL_CLR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opcode_q <= '0; cnt_q <= '0; rate_q <= 2'b11;
      end else if (acc_wr) begin
         case (reg_addr)
            OFS_OPCODE: opcode_q <= reg_wdata;
            OFS_COUNT:  cnt_q <= {clamp_cnt(reg_wdata[7:4], 4'(MAX_CNT)),
                                  clamp_cnt(reg_wdata[3:0], 4'(MAX_CNT))};
            OFS_CFG:    rate_q <= reg_wdata[5:4];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (reg_addr)
         OFS_OPCODE: reg_rdata = opcode_q;
         OFS_COUNT:  reg_rdata = cnt_q;
         OFS_CTRL:   reg_rdata = {7'd0, busy};
         OFS_DATA:   reg_rdata = ring_cur;
         OFS_CFG:    reg_rdata = {2'b00, rate_q, 1'b0, 3'(ptr)};
         default:    reg_rdata = 8'h00;
      endcase
   end

   spi_rate_sel #(.DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW), .DIV_W(DIV_W))
      u_rate (.rate(rate_q), .div(div), .low_len(low_len));

   spi_ring_buf #(.DEPTH(DEPTH), .DW(8)) u_ring (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .we(eng_we | host_data_wr),
      .adv(eng_we | host_data_wr | host_data_rd),
      .wdata(eng_we ? eng_wdata : reg_wdata),
      .ptr(ptr), .cur(ring_cur), .nxt(ring_nxt));

   spi_seq #(.CNT_W(CNT_W), .DIV_W(DIV_W), .IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(go), .opcode(opcode_q),
      .wr_cnt(cnt_q[3:0]), .rd_cnt(cnt_q[7:4]), .div(div), .low_len(low_len),
      .ring_cur(ring_cur), .ring_nxt(ring_nxt), .miso(spi_miso),
      .busy(busy), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n),
      .ring_we(eng_we), .ring_wdata(eng_wdata));

   // R10: configuration is frozen for the whole command
   p_regs_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(opcode_q) && $stable(cnt_q) && $stable(rate_q)));
   // R4: an accepted go request makes the block busy next cycle
   p_go_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !busy && reg_addr == OFS_CTRL && reg_wdata[CTRL_GO_BIT]) |=> busy);
   // R2: stored counts never exceed the limit
   p_cnt_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[3:0] <= 4'(MAX_CNT)) && (cnt_q[7:4] <= 4'(MAX_CNT)));
endmodule

// File: tb/spi_cmd_engine_test.sv
`timescale 1ns/1ps
module spi_cmd_engine_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] reg_addr = '0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       spi_sclk, spi_mosi, spi_cs_n;
   logic       spi_miso = 1'b0;

   spi_cmd_engine uut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

   always #(CLK_PERIOD/2) clk = ~clk;

   int nchk = 0, nbad = 0;
   bit done = 0;
   logic [7:0] ring [8];
   logic [7:0] resp [32];
   logic [7:0] mcap [32];
   int pos = 0, edges = 0, per_bad = 0, exp_div = 4, cyc = 0, last_rise = 0, rose_cyc = 0;
   logic [1:0] rate_m = 2'b11;

   always @(posedge clk) cyc++;
   always @(negedge spi_cs_n) begin pos = 0; spi_miso = resp[0][7]; end
   always @(posedge spi_cs_n) rose_cyc = cyc;
   always @(posedge spi_sclk) begin
      mcap[pos/8] = {mcap[pos/8][6:0], spi_mosi};
      if (edges > 0 && (cyc - last_rise) != exp_div) per_bad++;
      last_rise = cyc;
      edges++;
   end
   always @(negedge spi_sclk) begin
      pos++;
      spi_miso = resp[pos/8][7 - (pos % 8)];
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_rd = 1'b1;
      #(CLK_PERIOD/4) d = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   function automatic int div_of(input logic [1:0] r);
      return (r == 2'b01) ? 2 : (r == 2'b10) ? 3 : 4;
   endfunction

   task automatic check_ring(input string tag);
      logic [7:0] v;
      int bad = 0;
      reg_write(4'h2, 8'h10);
      for (int i = 0; i < 8; i++) begin
         reg_read(4'hC, v);
         if (v !== ring[i]) bad++;
      end
      check(bad == 0, tag, bad, 0);
   endtask

   task automatic run_cmd(input logic [7:0] op, input int w, input int r,
                          input logic [1:0] rate, input bit poke);
      logic [7:0] v;
      logic [7:0] wb [8];
      int bad, polls;
      exp_div = div_of(rate);
      reg_write(4'h2, 8'h10);
      for (int k = 0; k < w; k++) begin
         wb[k] = 8'($urandom);
         reg_write(4'hC, wb[k]);
         ring[k] = wb[k];
      end
      reg_write(4'h2, 8'h10);
      reg_write(4'h1, {4'(r), 4'(w)});
      reg_write(4'h0, op);
      reg_write(4'hD, {2'b00, rate, 4'h0});
      rate_m = rate;
      for (int k = 0; k < 32; k++) resp[k] = 8'($urandom);
      edges = 0; per_bad = 0;
      reg_write(4'h2, 8'h01);
      reg_read(4'h2, v);
      check(v[0] == 1'b1, "R4 go bit reads busy", v, 1);
      if (poke) begin
         reg_write(4'h0, ~op);
         reg_write(4'h1, 8'h00);
         reg_write(4'hC, 8'hA5);
         reg_write(4'h2, 8'h10);
         reg_write(4'hD, 8'h00);
         reg_read(4'hC, v);
      end
      polls = 0;
      do begin reg_read(4'h2, v); polls++; end while (v[0] && polls < 3000);
      check(v[0] == 1'b0, "R4 go bit self-clears", v, 0);
      check((cyc - rose_cyc) >= exp_div, "R9 deselect gap", cyc - rose_cyc, exp_div);
      check(edges == 8 * (1 + w + r), "R7 sclk edge count", edges, 8 * (1 + w + r));
      check(per_bad == 0, "R8 sclk period", per_bad, 0);
      bad = 0;
      if (mcap[0] !== op) bad++;
      for (int k = 1; k <= w + r; k++)
         if (mcap[k] !== ((k <= w) ? wb[k-1] : 8'hFF)) bad++;
      check(bad == 0, "R5 mosi byte stream", bad, 0);
      reg_read(4'h1, v);
      check(v == {4'(r), 4'(w)}, poke ? "R10 counts kept while busy" : "R2 counts unchanged",
            v, {4'(r), 4'(w)});
      reg_read(4'h0, v);
      check(v == op, "R10 opcode kept", v, op);
      reg_read(4'hD, v);
      check(v == {2'b00, rate, 1'b0, 3'(w + r)}, "R6 pointer after command",
            v, {2'b00, rate, 1'b0, 3'(w + r)});
      for (int k = 1; k <= w + r; k++) ring[(k - 1) % 8] = resp[k];
      check_ring(poke ? "R10 ring unaffected by busy writes" : "R6 ring contents");
   endtask

   initial begin
      logic [7:0] v;
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < 8; i++) ring[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #(CLK_PERIOD/4);
      check(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 spi pins idle", {spi_cs_n, spi_sclk}, 2);
      reg_read(4'h0, v); check(v == 8'h00, "R1 opcode reset", v, 0);
      reg_read(4'h1, v); check(v == 8'h00, "R1 counts reset", v, 0);
      reg_read(4'h2, v); check(v == 8'h00, "R1 control reset", v, 0);
      reg_read(4'hD, v); check(v == 8'h30, "R1 config reset", v, 8'h30);

      reg_write(4'h1, 8'hF9);
      reg_read(4'h1, v); check(v == 8'h88, "R2 count clamp", v, 8'h88);
      reg_write(4'h1, 8'h35);
      reg_read(4'h1, v); check(v == 8'h35, "R2 count store", v, 8'h35);

      reg_write(4'h2, 8'h10);
      for (int i = 0; i < 10; i++) begin
         reg_write(4'hC, 8'(8'h40 + i));
         ring[i % 8] = 8'(8'h40 + i);
      end
      reg_read(4'hD, v); check(v[2:0] == 3'd2, "R3 pointer wraps", v[2:0], 2);
      check_ring("R3 data port ring");
      reg_read(4'hD, v); check(v[2:0] == 3'd0, "R3 read advance wraps", v[2:0], 0);

      run_cmd(8'h9F, 0, 3, 2'b01, 1'b0);
      run_cmd(8'h03, 0, 1, 2'b10, 1'b0);
      run_cmd(8'h02, 8, 8, 2'b11, 1'b0);
      run_cmd(8'h06, 4, 0, 2'b00, 1'b0);
      run_cmd(8'h0B, 3, 2, 2'b01, 1'b1);
      for (int t = 0; t < 10; t++)
         run_cmd(8'($urandom), int'($urandom % 9), int'($urandom % 9),
                 2'($urandom), 1'b0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         nchk++; nbad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end
endmodule